// File: doc/BRIEF.md
# Pipeline Epoch Redirect Controller

This block recovers an in-order six-stage pipeline from branch mispredictions. It holds the program counter and two one-bit epochs. The decode stage owns one epoch and the execute stage owns the other. Fetch takes the current PC and both epoch values and tags each new instruction with them. When decode or execute finds that control flow went the wrong way, it raises a redirect carrying the corrected target and the epoch tags of its own instruction.

The controller settles both redirect requests within one cycle, with execute ordered ahead of decode. It applies the winning request as a single update of the PC and the matching epoch. The redirected PC and epochs go straight to the fetch outputs in the same cycle. Each cycle it also returns a verdict for the decode instruction and for the execute instruction. A wrong-path instruction in decode is killed. A wrong-path instruction in execute is poisoned: it travels on to writeback but commits nothing. A redirect from an instruction that is already on the wrong path is dropped.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the PC equals RESET_VEC (0x0100 in the bench configuration), both epochs are 0, redirect_src_o is 0 and both verdicts are 0.
- R2: When no redirect takes effect, the PC advances by PC_STEP (4) on a cycle with fetch_ready_i high and holds on a cycle with it low.
- R3: An execute instruction that is valid, mispredicted and whose epoch tag equals the current execute epoch redirects the PC. In that same cycle fetch_pc_o equals exe_target_i, fetch_eepoch_o is inverted, fetch_depoch_o is unchanged and redirect_src_o is 2.
- R4: An execute instruction whose execute-epoch tag differs from the current execute epoch gets verdict 3 (poison) and never redirects, even when it is marked mispredicted.
- R5: A decode instruction whose decode-epoch tag or execute-epoch tag differs from the current value gets verdict 2 (kill) and never redirects.
- R6: A decode instruction that is valid, mispredicted and has both tags current redirects the PC when execute does not. In that cycle fetch_pc_o equals dec_target_i, fetch_depoch_o is inverted, fetch_eepoch_o is unchanged and redirect_src_o is 1.
- R7: When execute redirects in a cycle, a valid decode instruction in that cycle is killed (verdict 2), its redirect is ignored and the decode epoch is unchanged.
- R8: After an execute redirect, a decode misprediction on the next cycle whose instruction carries the old execute epoch is killed and does not move the PC.
- R9: After a decode redirect, an execute misprediction on the next cycle with a current tag still redirects, and the decode epoch keeps its flipped value.
- R10: A verdict output is 0 when its stage input is not valid, and 1 (keep) for a valid instruction with current tags that is not blocked.
- R11: After a redirect the PC continues from the new target: on the next cycle it reads target + 4 if fetch_ready_i was high in the redirect cycle and reads target if it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_ready_i | input | 1 | Fetch takes the current address this cycle |
| fetch_pc_o | output | ADDR_W | Fetch address, already redirected this cycle |
| fetch_depoch_o | output | 1 | Decode epoch to tag the fetched instruction |
| fetch_eepoch_o | output | 1 | Execute epoch to tag the fetched instruction |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_depoch_i | input | 1 | Decode-epoch tag of the decode instruction |
| dec_eepoch_i | input | 1 | Execute-epoch tag of the decode instruction |
| dec_mispred_i | input | 1 | Decode found a misprediction |
| dec_target_i | input | ADDR_W | Corrected target from decode |
| exe_valid_i | input | 1 | Execute holds an instruction |
| exe_eepoch_i | input | 1 | Execute-epoch tag of the execute instruction |
| exe_mispred_i | input | 1 | Execute found a misprediction |
| exe_target_i | input | ADDR_W | Corrected target from execute |
| dec_verdict_o | output | 2 | 0 none, 1 keep, 2 kill |
| exe_verdict_o | output | 2 | 0 none, 1 keep, 3 poison |
| redirect_src_o | output | 2 | 0 none, 1 decode, 2 execute |

## Verification
The bench sweeps every combination of valid, mispredict, tag-match and fetch-ready across both stages. It does this from PC and epoch states that the sweep itself keeps changing, and a model in the bench tracks the expected PC and epochs. With execute and decode both redirecting in the same cycle, a design with the priority reversed would move the PC to the decode target and flip the wrong epoch. A design that did not block the decode request would flip both epochs. Directed back-to-back sequences cover two more errors: letting a wrong-path decode instruction redirect after an execute redirect, and letting an earlier decode redirect mask a later execute one. The sweep also catches a design that compares only one of decode's two tags, since it would keep instructions it should kill.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_KEEP   = 2'd1,
    VERD_KILL   = 2'd2,
    VERD_POISON = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEC  = 2'd1,
    SRC_EXE  = 2'd2
  } redir_src_e;
endpackage

// File: rtl/erc_stage_judge.sv
module erc_stage_judge
  import erc_pkg::*;
#(
  parameter logic [1:0] STALE_CODE = VERD_KILL
) (
  input  logic       valid_i,
  input  logic       mispred_i,
  input  logic       tag_ok_i,
  input  logic       block_i,
  output logic [1:0] verdict_o,
  output logic       redir_o
);
  logic wrong_path;

  assign wrong_path = !tag_ok_i || block_i;

  always_comb begin
    if (!valid_i)        verdict_o = VERD_NONE;
    else if (wrong_path) verdict_o = STALE_CODE;
    else                 verdict_o = VERD_KEEP;
  end

  assign redir_o = valid_i && mispred_i && !wrong_path;
endmodule

// File: rtl/erc_redirect_mux.sv
module erc_redirect_mux
  import erc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic [ADDR_W-1:0] pc_q_i,
  input  logic              depoch_q_i,
  input  logic              eepoch_q_i,
  input  logic              exe_redir_i,
  input  logic [ADDR_W-1:0] exe_target_i,
  input  logic              dec_redir_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              fetch_depoch_o,
  output logic              fetch_eepoch_o,
  output logic [ADDR_W-1:0] pc_d_o,
  output logic [1:0]        src_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  // execute is ordered first, decode second, fetch reads the result
  always_comb begin
    fetch_pc_o     = pc_q_i;
    fetch_depoch_o = depoch_q_i;
    fetch_eepoch_o = eepoch_q_i;
    src_o          = SRC_NONE;
    if (exe_redir_i) begin
      fetch_pc_o     = exe_target_i;
      fetch_eepoch_o = !eepoch_q_i;
      src_o          = SRC_EXE;
    end else if (dec_redir_i) begin
      fetch_pc_o     = dec_target_i;
      fetch_depoch_o = !depoch_q_i;
      src_o          = SRC_DEC;
    end
  end

  assign pc_d_o = fetch_ready_i ? fetch_pc_o + STEP : fetch_pc_o;
endmodule

// File: rtl/erc_state.sv
module erc_state #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_d_i,
  input  logic              depoch_d_i,
  input  logic              eepoch_d_i,
  output logic [ADDR_W-1:0] pc_q_o,
  output logic              depoch_q_o,
  output logic              eepoch_q_o
);
  // PC and both epochs share one update edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q_o     <= RESET_VEC;
      depoch_q_o <= 1'b0;
      eepoch_q_o <= 1'b0;
    end else begin
      pc_q_o     <= pc_d_i;
      depoch_q_o <= depoch_d_i;
      eepoch_q_o <= eepoch_d_i;
    end
  end
endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl
  import erc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       PC_STEP   = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              fetch_depoch_o,
  output logic              fetch_eepoch_o,
  input  logic              dec_valid_i,
  input  logic              dec_depoch_i,
  input  logic              dec_eepoch_i,
  input  logic              dec_mispred_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic              exe_valid_i,
  input  logic              exe_eepoch_i,
  input  logic              exe_mispred_i,
  input  logic [ADDR_W-1:0] exe_target_i,
  output logic [1:0]        dec_verdict_o,
  output logic [1:0]        exe_verdict_o,
  output logic [1:0]        redirect_src_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              depoch_q, eepoch_q;
  logic              exe_redir, dec_redir;
  logic              exe_tag_ok, dec_tag_ok;

  assign exe_tag_ok = (exe_eepoch_i == eepoch_q);
  assign dec_tag_ok = (dec_depoch_i == depoch_q) && (dec_eepoch_i == eepoch_q);

  erc_stage_judge #(.STALE_CODE(VERD_POISON)) u_exe_judge (
    .valid_i   (exe_valid_i),
    .mispred_i (exe_mispred_i),
    .tag_ok_i  (exe_tag_ok),
    .block_i   (1'b0),
    .verdict_o (exe_verdict_o),
    .redir_o   (exe_redir)
  );

  // a live execute redirect puts the decode instruction on the wrong path
  erc_stage_judge #(.STALE_CODE(VERD_KILL)) u_dec_judge (
    .valid_i   (dec_valid_i),
    .mispred_i (dec_mispred_i),
    .tag_ok_i  (dec_tag_ok),
    .block_i   (exe_redir),
    .verdict_o (dec_verdict_o),
    .redir_o   (dec_redir)
  );

  erc_redirect_mux #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_mux (
    .pc_q_i         (pc_q),
    .depoch_q_i     (depoch_q),
    .eepoch_q_i     (eepoch_q),
    .exe_redir_i    (exe_redir),
    .exe_target_i   (exe_target_i),
    .dec_redir_i    (dec_redir),
    .dec_target_i   (dec_target_i),
    .fetch_ready_i  (fetch_ready_i),
    .fetch_pc_o     (fetch_pc_o),
    .fetch_depoch_o (fetch_depoch_o),
    .fetch_eepoch_o (fetch_eepoch_o),
    .pc_d_o         (pc_d),
    .src_o          (redirect_src_o)
  );

  erc_state #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_d_i     (pc_d),
    .depoch_d_i (fetch_depoch_o),
    .eepoch_d_i (fetch_eepoch_o),
    .pc_q_o     (pc_q),
    .depoch_q_o (depoch_q),
    .eepoch_q_o (eepoch_q)
  );
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PC_STEP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_ready_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              fetch_depoch_o,
  input logic              fetch_eepoch_o,
  input logic              dec_valid_i,
  input logic              dec_depoch_i,
  input logic              dec_eepoch_i,
  input logic              dec_mispred_i,
  input logic [ADDR_W-1:0] dec_target_i,
  input logic              exe_valid_i,
  input logic              exe_eepoch_i,
  input logic              exe_mispred_i,
  input logic [ADDR_W-1:0] exe_target_i,
  input logic [1:0]        dec_verdict_o,
  input logic [1:0]        exe_verdict_o,
  input logic [1:0]        redirect_src_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fetch_ready_i) && redirect_src_o == 2'd0
    |-> fetch_pc_o == $past(fetch_pc_o) + STEP); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(fetch_ready_i) && redirect_src_o == 2'd0
    |-> fetch_pc_o == $past(fetch_pc_o)); // R2
  AST_EPOCH_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && redirect_src_o == 2'd0
    |-> fetch_eepoch_o == $past(fetch_eepoch_o) && fetch_depoch_o == $past(fetch_depoch_o)); // R2
  AST_EXE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_src_o == 2'd2 |-> fetch_pc_o == exe_target_i && exe_mispred_i); // R3
  AST_EXE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && redirect_src_o == 2'd2
    |-> fetch_eepoch_o != $past(fetch_eepoch_o) && fetch_depoch_o == $past(fetch_depoch_o)); // R3
  AST_EXE_STALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && exe_valid_i && exe_eepoch_i != $past(fetch_eepoch_o)
    |-> exe_verdict_o == 2'd3 && redirect_src_o != 2'd2); // R4
  AST_DEC_STALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && dec_valid_i
    && (dec_depoch_i != $past(fetch_depoch_o) || dec_eepoch_i != $past(fetch_eepoch_o))
    |-> dec_verdict_o == 2'd2 && redirect_src_o != 2'd1); // R5
  AST_DEC_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_src_o == 2'd1 |-> fetch_pc_o == dec_target_i && dec_mispred_i); // R6
  AST_DEC_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && redirect_src_o == 2'd1
    |-> fetch_depoch_o != $past(fetch_depoch_o) && fetch_eepoch_o == $past(fetch_eepoch_o)); // R6
  AST_EXE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_verdict_o == 2'd1 && exe_mispred_i && dec_valid_i
    |-> redirect_src_o == 2'd2 && dec_verdict_o == 2'd2); // R7
  AST_IDLE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i && !exe_valid_i
    |-> dec_verdict_o == 2'd0 && exe_verdict_o == 2'd0 && redirect_src_o == 2'd0); // R10
endmodule

bind epoch_redirect_ctrl erc_checker #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_chk (.*);

// File: tb/epoch_redirect_ctrl_tb.sv
module epoch_redirect_ctrl_tb;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr = 1'b0;
  logic [AW-1:0] fpc;
  logic fde, fee;
  logic dv = 0, dde = 0, dee = 0, dm = 0;
  logic [AW-1:0] dt = '0;
  logic xv = 0, xee = 0, xm = 0;
  logic [AW-1:0] xt = '0;
  logic [1:0] dverd, xverd, src;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] pc_m = RV;
  logic de_m = 1'b0, ee_m = 1'b0;

  always #10 clk = ~clk;

  epoch_redirect_ctrl #(.ADDR_W(AW), .PC_STEP(4), .RESET_VEC(RV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_ready_i(fr),
    .fetch_pc_o(fpc), .fetch_depoch_o(fde), .fetch_eepoch_o(fee),
    .dec_valid_i(dv), .dec_depoch_i(dde), .dec_eepoch_i(dee),
    .dec_mispred_i(dm), .dec_target_i(dt),
    .exe_valid_i(xv), .exe_eepoch_i(xee), .exe_mispred_i(xm), .exe_target_i(xt),
    .dec_verdict_o(dverd), .exe_verdict_o(xverd), .redirect_src_o(src)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // tag mismatch flags are relative to the bench model state
  task automatic step(input bit v_d, m_d, dd_mis, de_mis, input logic [AW-1:0] t_d,
                      input bit v_x, m_x, xe_mis, input logic [AW-1:0] t_x,
                      input bit rdy, input string tag_in);
    bit d_stale, x_red, d_red;
    int e_dv, e_xv, e_src;
    logic [AW-1:0] e_pc;
    string tag;
    @(negedge clk);
    dv = v_d; dm = m_d; dde = de_m ^ dd_mis; dee = ee_m ^ de_mis; dt = t_d;
    xv = v_x; xm = m_x; xee = ee_m ^ xe_mis; xt = t_x; fr = rdy;
    #5;
    d_stale = dd_mis || de_mis;
    x_red = v_x && m_x && !xe_mis;
    d_red = v_d && m_d && !d_stale && !x_red;
    e_dv = !v_d ? 0 : ((d_stale || x_red) ? 2 : 1);
    e_xv = !v_x ? 0 : (xe_mis ? 3 : 1);
    e_pc = x_red ? t_x : (d_red ? t_d : pc_m);
    e_src = x_red ? 2 : (d_red ? 1 : 0);
    if (tag_in != "") tag = tag_in;
    else if (x_red && v_d) tag = "R7";
    else if (x_red) tag = "R3";
    else if (d_red) tag = "R6";
    else if (v_d && d_stale) tag = "R5";
    else if (v_x && xe_mis) tag = "R4";
    else if (rdy) tag = "R2";
    else tag = "R10";
    chk(tag, "dec_verdict", int'(dverd), e_dv);
    chk(tag, "exe_verdict", int'(xverd), e_xv);
    chk(tag, "src", int'(src), e_src);
    chk(tag, "fetch_pc", int'(fpc), int'(e_pc));
    chk(tag, "eepoch", int'(fee), int'(ee_m ^ x_red));
    chk(tag, "depoch", int'(fde), int'(de_m ^ d_red));
    ee_m = ee_m ^ x_red;
    de_m = de_m ^ d_red;
    pc_m = rdy ? e_pc + 16'd4 : e_pc;
  endtask

  task automatic idle(input bit rdy, input string tag);
    step(0, 0, 0, 0, '0, 0, 0, 0, '0, rdy, tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #15;
    chk("R1", "pc_in_reset", int'(fpc), int'(RV));
    chk("R1", "epochs_in_reset", int'({fde, fee}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "pc", int'(fpc), int'(RV));
    chk("R1", "epochs", int'({fde, fee}), 0);
    chk("R1", "verdicts", int'({dverd, xverd}), 0);
    chk("R1", "src", int'(src), 0);

    idle(1, "R2");
    idle(0, "R2");
    idle(1, "R10");
    // R10: plain keep in both stages
    step(1, 0, 0, 0, 16'h0AA0, 1, 0, 0, 16'h0BB0, 1, "R10");

    // R11: redirect with and without a fetch handshake
    step(0, 0, 0, 0, '0, 1, 1, 0, 16'h3000, 1, "R11");
    idle(0, "R11");
    step(1, 1, 0, 0, 16'h3400, 0, 0, 0, '0, 0, "R11");
    idle(1, "R11");

    // R8: execute redirect, then decode mispredict carrying the old execute epoch
    step(1, 1, 0, 0, 16'h4100, 1, 1, 0, 16'h4000, 1, "R8");
    step(1, 1, 0, 1, 16'h4200, 0, 0, 0, '0, 1, "R8");
    idle(1, "R8");

    // R9: decode redirect, then execute redirect on the next cycle
    step(1, 1, 0, 0, 16'h5000, 1, 0, 0, '0, 1, "R9");
    step(1, 0, 1, 0, 16'h0000, 1, 1, 0, 16'h5800, 1, "R9");
    idle(0, "R9");

    // exhaustive sweep over stage events and handshake from evolving state
    for (int i = 0; i < 256; i++) begin
      step(i[0], i[1], i[2], i[3], 16'h2000 + 16'(i * 4),
           i[4], i[5], i[6], 16'h6000 + 16'(i * 8), i[7], "");
    end
    for (int i = 0; i < 256; i++) begin
      step(i[7], i[6], i[5], i[4], 16'h7000 + 16'(i * 4),
           i[3], i[2], i[1], 16'h8000 + 16'(i * 4), i[0], "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule